// File: doc/BRIEF.md
# Master Interrupt Source Router

This block is the system-level interrupt router shared by a group of processors. It samples 32 level-sensitive device interrupt lines into a pending register and masks them with a disable register. It then converts every source that is both pending and enabled into a processor priority level, using a fixed and irregular source-to-level mapping. The resulting 16-bit level vector is delivered on the output slice of one software-selected target processor. Every other processor's slice stays at zero.

A small 32-bit register port handles access. The word index is the byte address divided by four, and the window spans five words. Software can read the pending lines, the disable mask and the target index. It can set or clear disable bits, and it can choose the target. The top bit of the disable register is a global switch that withholds every hard level. Sources mapped to the highest level also produce one-cycle broadcast strobes when they assert or deassert, so that the per-processor logic can track that level.

Top module: `irq_route_master`

## Requirements
- R1: Word index = `bus_addr[4:2]`. Read data and `bus_rvalid` appear the cycle after `bus_rd`. Reads of word indices 2, 3, 5, 6 and 7 return zero, and writes to words 0 and 1 change nothing.
- R2: Word 0 reads the pending register, which takes the input levels one clock after they are applied. Sources whose level is 0 (bits 23–26 and 31) are never pending, so bit 31 always reads zero.
- R3: Word 1 reads the disable register ANDed with 0xF05DFF80.
- R4: A write to word 2 clears disable bits where `wdata & 0xF05DFF80` is one. A write to word 3 sets them. Neither write alters pending.
- R5: A write to word 4 loads the target index from the low 4 bits of the data. Word 4 reads the index back, and `tgt_cpu` shows it.
- R6: Level mapping for sources 0–31: 2,3,5,7,9,11,13, the same seven again, 12,12, 6,13,4,10,8,9,11, 0,0,0,0, 15,15,15,15, 0. The target slice has bit n set when any pending, enabled source maps to level n.
- R7: While disable bit 31 is set, `glob_off` is high and every slice of `cpu_lvl` is zero.
- R8: Only slice `cpu_lvl[16*t +: 16]` of the target t may be nonzero, and bit 0 of every slice is zero.
- R9: Disable bits outside 0xF05DFF80 keep their reset value of one. As a result, sources 0–6, 17, 21 and 27 can become pending but never produce a level.
- R10: In the cycle that pending updates, `l15_up` pulses for one cycle if a level-15 source became pending, and `l15_down` pulses if one was released.
- R11: Synchronous reset clears pending, the target index and both strobes. It loads the disable register with 0x0FA2007F, so word 1 reads 0 and `glob_off` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 32 | Device interrupt levels |
| bus_addr | input | 5 | Byte address into the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| cpu_lvl | output | NCPU*16 (256) | Hard-interrupt level vector per processor |
| tgt_cpu | output | 4 | Current target processor index |
| glob_off | output | 1 | Global disable flag |
| l15_up | output | 1 | Strobe: a level-15 source asserted |
| l15_down | output | 1 | Strobe: a level-15 source deasserted |

## Verification
The hardest state to reach from the ports combines many active sources, a partly disabled mask, a global disable and a non-zero target. In that state each term of the level equation has to be observed on its own. The stimulus drives eight sources together, chosen so that every mapped level is distinct. It then removes single levels by disabling single sources, toggles the global bit, and moves the target to processor 5, checking both the target slice and the former one. Sources that the reset mask disables permanently, and sources mapped to level 0, are driven separately. Their effects on the pending readback and on the level vector are checked apart.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int NSRC = 32;
  localparam int NLVL = 16;
  localparam int GOFF_BIT = 31;
  localparam logic [NSRC-1:0] IMPL_MASK = 32'hF05D_FF80;

  typedef enum logic [2:0] {
    W_PEND = 3'd0,
    W_DIS  = 3'd1,
    W_EN   = 3'd2,
    W_MASK = 3'd3,
    W_TGT  = 3'd4
  } word_e;

  function automatic logic [3:0] src_level(input int b);
    logic [3:0] lv;
    if (b < 14) begin
      case (b % 7)
        0: lv = 4'd2;
        1: lv = 4'd3;
        2: lv = 4'd5;
        3: lv = 4'd7;
        4: lv = 4'd9;
        5: lv = 4'd11;
        default: lv = 4'd13;
      endcase
    end else begin
      case (b)
        14, 15: lv = 4'd12;
        16: lv = 4'd6;
        17: lv = 4'd13;
        18: lv = 4'd4;
        19: lv = 4'd10;
        20: lv = 4'd8;
        21: lv = 4'd9;
        22: lv = 4'd11;
        27, 28, 29, 30: lv = 4'd15;
        default: lv = 4'd0;
      endcase
    end
    return lv;
  endfunction

  function automatic logic [NSRC-1:0] live_mask();
    logic [NSRC-1:0] m;
    for (int b = 0; b < NSRC; b++) m[b] = (src_level(b) != 4'd0);
    return m;
  endfunction

  function automatic logic [NSRC-1:0] top_mask();
    logic [NSRC-1:0] m;
    for (int b = 0; b < NSRC; b++) m[b] = (src_level(b) == 4'd15);
    return m;
  endfunction
endpackage

// File: rtl/irqr_pending.sv
module irqr_pending
  import irqr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] pend_o,
  output logic            up_o,
  output logic            down_o
);
  localparam logic [NSRC-1:0] LIVE = live_mask();
  localparam logic [NSRC-1:0] TOP  = top_mask();

  logic [NSRC-1:0] live;
  assign live = src_i & LIVE;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= '0;
      up_o   <= 1'b0;
      down_o <= 1'b0;
    end else begin
      pend_o <= live;
      up_o   <= |(live & ~pend_o & TOP);
      down_o <= |(~live & pend_o & TOP);
    end
  end

  // R10: a rise strobe means some level-15 source is now pending
  a_r10_up_has_top: assert property (@(posedge clk) disable iff (rst)
    up_o |-> ((pend_o & TOP) != '0));
  // R10: a fall strobe means some level-15 source was pending before
  a_r10_down_had_top: assert property (@(posedge clk) disable iff (rst)
    down_o |-> (($past(pend_o) & TOP) != '0));
endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int TGT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              rvalid_o,
  output logic [NSRC-1:0]   dis_o,
  output logic [TGT_W-1:0]  tgt_o
);
  logic [2:0]      word;
  logic [NSRC-1:0] dis_q;
  logic [NSRC-1:0] wmask;
  logic            unused_lowaddr;

  assign word           = addr_i[4:2];
  assign unused_lowaddr = ^addr_i[1:0];
  assign wmask          = wdata_i & IMPL_MASK;
  // unimplemented bits are held at one, so they can never be cleared
  assign dis_o          = dis_q | ~IMPL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q    <= '0;
      tgt_o    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) begin
        case (word)
          W_PEND:  rdata_o <= pend_i & ~(NSRC'(1) << GOFF_BIT);
          W_DIS:   rdata_o <= dis_q & IMPL_MASK;
          W_TGT:   rdata_o <= NSRC'(tgt_o);
          default: rdata_o <= '0;
        endcase
      end
      if (wr_i) begin
        case (word)
          W_EN:    dis_q <= dis_q & ~wmask;
          W_MASK:  dis_q <= dis_q | wmask;
          W_TGT:   tgt_o <= wdata_i[TGT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R5: a target write is visible on the next cycle
  a_r5_tgt_load: assert property (@(posedge clk) disable iff (rst)
    (wr_i && word == W_TGT) |=> (tgt_o == $past(wdata_i[TGT_W-1:0])));
  // R4: after an enable write, none of the written implemented bits remain disabled
  a_r4_enable_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_i && word == W_EN) |=> ((dis_o & $past(wdata_i) & IMPL_MASK) == '0));
  // R11: reset leaves target zero and no read pending
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (tgt_o == '0 && !rvalid_o && !dis_o[GOFF_BIT]));
endmodule

// File: rtl/irqr_levels.sv
module irqr_levels
  import irqr_pkg::*;
#(
  parameter int NCPU  = 16,
  parameter int TGT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC-1:0]    dis_i,
  input  logic [TGT_W-1:0]   tgt_i,
  output logic [NCPU*NLVL-1:0] cpu_lvl_o,
  output logic               goff_o
);
  logic [NSRC-1:0] act;
  logic [NLVL-1:0] hard;

  assign act    = pend_i & ~dis_i;
  assign goff_o = dis_i[GOFF_BIT];

  always_comb begin
    hard = '0;
    if (!goff_o) begin
      for (int b = 0; b < NSRC; b++) begin
        if (act[b]) hard[src_level(b)] = 1'b1;
      end
    end
    hard[0] = 1'b0;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_lvl_o[c*NLVL +: NLVL] = (tgt_i == TGT_W'(c)) ? hard : '0;

    // R8: a processor that is not the target sees no hard levels
    a_r8_off_target: assert property (@(posedge clk) disable iff (rst)
      (tgt_i != TGT_W'(c)) |-> (cpu_lvl_o[c*NLVL +: NLVL] == '0));
    // R8: level 0 is never signalled
    a_r8_no_level0: assert property (@(posedge clk) disable iff (rst)
      !cpu_lvl_o[c*NLVL]);
  end

  // R7: global disable silences every processor
  a_r7_goff_quiet: assert property (@(posedge clk) disable iff (rst)
    goff_o |-> (cpu_lvl_o == '0));
endmodule

// File: rtl/irq_route_master.sv
module irq_route_master
  import irqr_pkg::*;
#(
  parameter int NCPU   = 16,
  parameter int ADDR_W = 5,
  parameter int TGT_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src_lvl,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [NSRC-1:0]      bus_wdata,
  output logic [NSRC-1:0]      bus_rdata,
  output logic                 bus_rvalid,
  output logic [NCPU*NLVL-1:0] cpu_lvl,
  output logic [TGT_W-1:0]     tgt_cpu,
  output logic                 glob_off,
  output logic                 l15_up,
  output logic                 l15_down
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] dis;

  irqr_pending u_pend (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_lvl),
    .pend_o (pend),
    .up_o   (l15_up),
    .down_o (l15_down)
  );

  irqr_regs #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .rd_i     (bus_rd),
    .wdata_i  (bus_wdata),
    .pend_i   (pend),
    .rdata_o  (bus_rdata),
    .rvalid_o (bus_rvalid),
    .dis_o    (dis),
    .tgt_o    (tgt_cpu)
  );

  irqr_levels #(.NCPU(NCPU), .TGT_W(TGT_W)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend),
    .dis_i     (dis),
    .tgt_i     (tgt_cpu),
    .cpu_lvl_o (cpu_lvl),
    .goff_o    (glob_off)
  );
endmodule

// File: tb/irq_route_master_tb.sv
module irq_route_master_tb;
  localparam int NCPU = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_lvl = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NCPU*16-1:0] cpu_lvl;
  logic [3:0]  tgt_cpu;
  logic        glob_off, l15_up, l15_down;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_route_master #(.NCPU(NCPU)) u_dut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_lvl(cpu_lvl),
    .tgt_cpu(tgt_cpu), .glob_off(glob_off), .l15_up(l15_up), .l15_down(l15_down)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] slice(int c);
    return cpu_lvl[c*16 +: 16];
  endfunction

  // monitor: pops the scoreboard when read data arrives
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: unexpected read data 0x%08h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd_word(int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = 5'(idx << 2);
    bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_word(int idx, logic [31:0] val);
    @(negedge clk);
    bus_addr = 5'(idx << 2);
    bus_wdata = val;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic drive_src(logic [31:0] v);
    @(negedge clk);
    src_lvl = v;
    @(negedge clk);
  endtask

  localparam logic [31:0] MIX = 32'h105D_4100;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 / R3 reset state
    check("R11 levels", cpu_lvl[31:0], 32'h0);
    check("R11 glob_off", {31'h0, glob_off}, 32'h0);
    check("R11 tgt", {28'h0, tgt_cpu}, 32'h0);
    rd_word(0, 32'h0, "R11 pending");
    rd_word(1, 32'h0, "R3 disable after reset");
    rd_word(4, 32'h0, "R11 target");

    // R6 single source, level 2
    drive_src(32'h0000_0080);
    check("R6 src7 level2", {16'h0, slice(0)}, 32'h0004);
    rd_word(0, 32'h0000_0080, "R2 pending src7");

    // R9 permanently disabled sources still pend, give no level
    drive_src(32'h0002_0001);
    check("R9 src0/17 no level", {16'h0, slice(0)}, 32'h0);
    rd_word(0, 32'h0002_0001, "R9 pending src0/17");

    // R2 level-0 sources never pend
    drive_src(32'h8780_0000);
    rd_word(0, 32'h0, "R2 level0 sources");

    // R6 / R10 mixed pattern with a level-15 source rising
    drive_src(MIX);
    check("R10 up strobe", {31'h0, l15_up}, 32'h1);
    check("R6 mixed levels", {16'h0, slice(0)}, 32'h9D58);
    @(negedge clk);
    check("R10 up one cycle", {31'h0, l15_up}, 32'h0);
    rd_word(0, MIX, "R2 pending mixed");

    // R4 disable sources 8 and 14; unimplemented bits ignored
    wr_word(3, 32'h0000_417F);
    check("R4 masked levels", {16'h0, slice(0)}, 32'h8D50);
    rd_word(1, 32'h0000_4100, "R4 disable readback");
    rd_word(0, MIX, "R4 pending unchanged");
    wr_word(2, 32'h0000_0100);
    check("R4 enable src8", {16'h0, slice(0)}, 32'h8D58);
    rd_word(1, 32'h0000_4000, "R4 disable after clear");

    // R1 writes to words 0/1 ignored, other reads zero
    wr_word(0, 32'hFFFF_FFFF);
    wr_word(1, 32'hFFFF_FFFF);
    rd_word(1, 32'h0000_4000, "R1 word1 write ignored");
    rd_word(0, MIX, "R1 word0 write ignored");
    rd_word(2, 32'h0, "R1 word2 reads zero");
    rd_word(3, 32'h0, "R1 word3 reads zero");
    rd_word(5, 32'h0, "R1 word5 reads zero");
    rd_word(7, 32'h0, "R1 word7 reads zero");

    // R7 global disable
    wr_word(3, 32'h8000_0000);
    check("R7 glob_off", {31'h0, glob_off}, 32'h1);
    check("R7 levels silent", {16'h0, slice(0)}, 32'h0);
    rd_word(1, 32'h8000_4000, "R7 disable readback");
    wr_word(2, 32'h8000_0000);
    check("R7 restored", {16'h0, slice(0)}, 32'h8D58);

    // R5 / R8 retarget
    wr_word(4, 32'hFFFF_FFF5);
    check("R5 tgt port", {28'h0, tgt_cpu}, 32'h5);
    check("R8 target slice", {16'h0, slice(5)}, 32'h8D58);
    check("R8 old slice", {16'h0, slice(0)}, 32'h0);
    rd_word(4, 32'h5, "R5 target readback");

    // R10 falling level-15 source
    drive_src(MIX & ~32'h1000_0000);
    check("R10 down strobe", {31'h0, l15_down}, 32'h1);
    check("R6 level15 gone", {16'h0, slice(5)}, 32'h0D58);
    @(negedge clk);
    check("R10 down one cycle", {31'h0, l15_down}, 32'h0);

    drive_src(32'h0);
    check("R6 all released", {16'h0, slice(5)}, 32'h0);
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1: %0d reads unanswered expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule